// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of an SDRAM interface and brings the memory from power-up to a usable state. After reset it holds the command bus at NOP for a configurable settling window, then sends one precharge to all banks, two auto-refresh commands and one mode-register load. Between steps it waits a programmable number of clock cycles and keeps sending NOP. When the last wait has elapsed it raises a completion flag. Read/write scheduling and periodic refresh are handled elsewhere.

The mode word is built from four small input fields: burst length, burst ordering, CAS latency and operating mode. Every address bit above the operating-mode field is forced to zero. All wait lengths are parameters counted in clock cycles, so one instance covers any clock rate. A synchronous reset restarts the whole sequence from the settling window.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst` is high and in the cycle right after it, the command pins read NOP (`{cs_n,ras_n,cas_n,we_n}` = 0111), `sd_addr` and `sd_bank` are zero and `init_done` is low.
- R2: After reset is released, the command bus carries only NOP for exactly `PWR_CYC` cycles (at least one) before any other command.
- R3: The first command after the settling window is precharge-all: pins 0010, `sd_addr[10]` = 1 and every other address bit zero, `sd_bank` zero.
- R4: Exactly `T_RP` NOP cycles follow the precharge, and then the first auto-refresh is sent.
- R5: Two auto-refresh commands (pins 0001) are sent, each followed by exactly `T_RFC` NOP cycles.
- R6: Right after the second refresh wait, a load-mode command (pins 0000) is sent with `sd_addr[2:0]` = `mode_blen`, `sd_addr[3]` = `mode_seq_type`, `sd_addr[6:4]` = `mode_cas`, `sd_addr[8:7]` = `mode_op`, `sd_addr` bits 9 and up zero, and `sd_bank` zero.
- R7: Exactly `T_MRD` NOP cycles follow the load-mode command, and `init_done` rises in the next cycle.
- R8: Once high, `init_done` stays high and the bus stays at NOP until reset. A reset asserted mid-sequence restarts the sequence from R2.
- R9: In every NOP cycle, `sd_addr` and `sd_bank` are zero.
- R10: One complete sequence contains exactly one precharge, two auto-refreshes and one load-mode command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; restarts the sequence |
| mode_blen | input | 3 | Burst-length code placed in mode bits 2:0 |
| mode_seq_type | input | 1 | Burst ordering placed in mode bit 3 |
| mode_cas | input | 3 | CAS-latency code placed in mode bits 6:4 |
| mode_op | input | 2 | Operating-mode code placed in mode bits 8:7 |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address bus (precharge-all flag, mode word) |
| sd_bank | output | BANK_W | Bank select, held at zero |
| init_done | output | 1 | Sequence complete, held until reset |

## Verification
The mode fields are tried all-zero, all-one and with random values over several full sequences. All-zero shows whether mode bits are misplaced into the command cycle. All-one shows that the reserved upper address bits stay zero while each field reaches its own bit positions. Random values tell apart swapped or shifted fields. The bench compares every cycle against a timeline computed from the wait parameters, so an off-by-one in any wait shifts a command and is caught at once. Resets placed at random points inside the sequence check that the restart repeats the full settling window and not only part of it.

// File: rtl/sdi_pkg.sv
package sdi_pkg;

   typedef enum logic [3:0] {
      ST_PWR  = 4'd0,
      ST_PRE  = 4'd1,
      ST_TRP  = 4'd2,
      ST_REF1 = 4'd3,
      ST_RFC1 = 4'd4,
      ST_REF2 = 4'd5,
      ST_RFC2 = 4'd6,
      ST_LMR  = 4'd7,
      ST_MRD  = 4'd8,
      ST_DONE = 4'd9
   } sdi_state_e;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } sdi_cmd_t;

   localparam sdi_cmd_t CMD_NOP = 4'b0111;
   localparam sdi_cmd_t CMD_PRE = 4'b0010;
   localparam sdi_cmd_t CMD_REF = 4'b0001;
   localparam sdi_cmd_t CMD_LMR = 4'b0000;

   // Number of mode-word bits that carry fields; the rest are zero.
   localparam int unsigned MODE_FIELD_W = 9;
   // Address bit that selects all banks during precharge.
   localparam int unsigned ALLBANK_BIT  = 10;

   function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                           input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/sdi_wait_timer.sv
module sdi_wait_timer #(
   parameter int unsigned CNT_W   = 8,
   parameter int unsigned RST_VAL = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [CNT_W-1:0] len_m1,
   output logic             expired
);

   localparam logic [CNT_W-1:0] RST_CNT = CNT_W'(RST_VAL);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)                cnt_q <= RST_CNT;
      else if (start)         cnt_q <= len_m1;
      else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
   end

   assign expired = (cnt_q == '0);

   // R4: a running count moves down by one each cycle
   a_r4_timer_step: assert property (@(posedge clk) disable iff (rst)
      (!start && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

   // R2: a freshly loaded count equals the requested length
   a_r2_timer_load: assert property (@(posedge clk) disable iff (rst)
      start |=> (cnt_q == $past(len_m1)));

endmodule

// File: rtl/sdi_step_fsm.sv
module sdi_step_fsm
   import sdi_pkg::*;
#(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned T_RP  = 2,
   parameter int unsigned T_RFC = 6,
   parameter int unsigned T_MRD = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tmr_expired,
   output logic             tmr_start,
   output logic [CNT_W-1:0] tmr_len_m1,
   output sdi_state_e       state
);

   localparam logic [CNT_W-1:0] RP_M1  = CNT_W'(T_RP - 1);
   localparam logic [CNT_W-1:0] RFC_M1 = CNT_W'(T_RFC - 1);
   localparam logic [CNT_W-1:0] MRD_M1 = CNT_W'(T_MRD - 1);

   sdi_state_e state_q, state_d;

   always_comb begin
      state_d    = state_q;
      tmr_start  = 1'b0;
      tmr_len_m1 = '0;
      unique case (state_q)
         ST_PWR:  if (tmr_expired) state_d = ST_PRE;
         ST_PRE:  begin
            tmr_start  = 1'b1;
            tmr_len_m1 = RP_M1;
            state_d    = ST_TRP;
         end
         ST_TRP:  if (tmr_expired) state_d = ST_REF1;
         ST_REF1: begin
            tmr_start  = 1'b1;
            tmr_len_m1 = RFC_M1;
            state_d    = ST_RFC1;
         end
         ST_RFC1: if (tmr_expired) state_d = ST_REF2;
         ST_REF2: begin
            tmr_start  = 1'b1;
            tmr_len_m1 = RFC_M1;
            state_d    = ST_RFC2;
         end
         ST_RFC2: if (tmr_expired) state_d = ST_LMR;
         ST_LMR:  begin
            tmr_start  = 1'b1;
            tmr_len_m1 = MRD_M1;
            state_d    = ST_MRD;
         end
         ST_MRD:  if (tmr_expired) state_d = ST_DONE;
         ST_DONE: state_d = ST_DONE;
         default: state_d = ST_PWR;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_PWR;
      else     state_q <= state_d;
   end

   assign state = state_q;

   // R10: the load-mode step is entered only from the second refresh wait
   a_r10_lmr_order: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_LMR) |-> ($past(state_q) == ST_RFC2));

   // R5: the second refresh is entered only from the first refresh wait
   a_r5_ref2_order: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_REF2) |-> ($past(state_q) == ST_RFC1));

endmodule

// File: rtl/sdi_mode_word.sv
module sdi_mode_word
   import sdi_pkg::*;
#(
   parameter int unsigned ADDR_W = 12
) (
   input  logic [2:0]        blen,
   input  logic              seq_type,
   input  logic [2:0]        cas_lat,
   input  logic [1:0]        op_mode,
   output logic [ADDR_W-1:0] word
);

   assign word[2:0] = blen;
   assign word[3]   = seq_type;
   assign word[6:4] = cas_lat;
   assign word[8:7] = op_mode;

   for (genvar i = MODE_FIELD_W; i < ADDR_W; i++) begin : g_rsv
      assign word[i] = 1'b0;
   end

endmodule

// File: rtl/sdi_cmd_drive.sv
module sdi_cmd_drive
   import sdi_pkg::*;
#(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned BANK_W = 2
) (
   input  sdi_state_e        state,
   input  logic [ADDR_W-1:0] mode_word,
   output sdi_cmd_t          cmd,
   output logic [ADDR_W-1:0] addr,
   output logic [BANK_W-1:0] bank,
   output logic              done
);

   always_comb begin
      cmd  = CMD_NOP;
      addr = '0;
      bank = '0;
      unique case (state)
         ST_PRE: begin
            cmd               = CMD_PRE;
            addr[ALLBANK_BIT] = 1'b1;
         end
         ST_REF1, ST_REF2: cmd = CMD_REF;
         ST_LMR: begin
            cmd  = CMD_LMR;
            addr = mode_word;
         end
         default: cmd = CMD_NOP;
      endcase
   end

   assign done = (state == ST_DONE);

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
   import sdi_pkg::*;
#(
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned BANK_W  = 2,
   parameter int unsigned PWR_CYC = 20000,
   parameter int unsigned T_RP    = 4,
   parameter int unsigned T_RFC   = 14,
   parameter int unsigned T_MRD   = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [2:0]        mode_blen,
   input  logic              mode_seq_type,
   input  logic [2:0]        mode_cas,
   input  logic [1:0]        mode_op,
   output logic              sd_cs_n,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic [ADDR_W-1:0] sd_addr,
   output logic [BANK_W-1:0] sd_bank,
   output logic              init_done
);

   localparam int unsigned MAX_WAIT = max_of4(PWR_CYC, T_RP, T_RFC, T_MRD);
   localparam int unsigned CNT_W    = (MAX_WAIT < 2) ? 1 : $clog2(MAX_WAIT);

   if (ADDR_W <= ALLBANK_BIT) begin : g_chk_addr
      $error("ADDR_W must exceed the all-bank precharge bit");
   end
   if (BANK_W < 1) begin : g_chk_bank
      $error("BANK_W must be at least 1");
   end
   if (PWR_CYC < 1 || T_RP < 1 || T_RFC < 1 || T_MRD < 1) begin : g_chk_wait
      $error("every wait must be at least one cycle");
   end

   logic             tmr_start;
   logic             tmr_expired;
   logic [CNT_W-1:0] tmr_len_m1;
   sdi_state_e       state;
   logic [ADDR_W-1:0] mode_word;
   sdi_cmd_t         cmd;

   sdi_wait_timer #(
      .CNT_W   (CNT_W),
      .RST_VAL (PWR_CYC - 1)
   ) u_timer (
      .clk     (clk),
      .rst     (rst),
      .start   (tmr_start),
      .len_m1  (tmr_len_m1),
      .expired (tmr_expired)
   );

   sdi_step_fsm #(
      .CNT_W (CNT_W),
      .T_RP  (T_RP),
      .T_RFC (T_RFC),
      .T_MRD (T_MRD)
   ) u_fsm (
      .clk         (clk),
      .rst         (rst),
      .tmr_expired (tmr_expired),
      .tmr_start   (tmr_start),
      .tmr_len_m1  (tmr_len_m1),
      .state       (state)
   );

   sdi_mode_word #(
      .ADDR_W (ADDR_W)
   ) u_mode (
      .blen     (mode_blen),
      .seq_type (mode_seq_type),
      .cas_lat  (mode_cas),
      .op_mode  (mode_op),
      .word     (mode_word)
   );

   sdi_cmd_drive #(
      .ADDR_W (ADDR_W),
      .BANK_W (BANK_W)
   ) u_drive (
      .state     (state),
      .mode_word (mode_word),
      .cmd       (cmd),
      .addr      (sd_addr),
      .bank      (sd_bank),
      .done      (init_done)
   );

   assign sd_cs_n  = cmd.cs_n;
   assign sd_ras_n = cmd.ras_n;
   assign sd_cas_n = cmd.cas_n;
   assign sd_we_n  = cmd.we_n;

   // R8: completion is sticky until reset
   a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
      init_done |=> init_done);

   // R8: after completion the bus carries only NOP
   a_r8_done_nop: assert property (@(posedge clk) disable iff (rst)
      init_done |-> (cmd == CMD_NOP));

   // R7: completion follows a NOP cycle
   a_r7_done_after_nop: assert property (@(posedge clk) disable iff (rst)
      $rose(init_done) |-> ($past(cmd) == CMD_NOP));

   // R5: every refresh is followed by a NOP cycle
   a_r5_ref_then_nop: assert property (@(posedge clk) disable iff (rst)
      (cmd == CMD_REF) |=> (cmd == CMD_NOP));

   // R3: precharge selects all banks
   a_r3_pre_allbank: assert property (@(posedge clk) disable iff (rst)
      (cmd == CMD_PRE) |-> (sd_addr[ALLBANK_BIT] && sd_bank == '0));

   // R6: load-mode reserved bits stay zero
   a_r6_lmr_reserved: assert property (@(posedge clk) disable iff (rst)
      (cmd == CMD_LMR) |-> ((sd_addr >> MODE_FIELD_W) == '0 && sd_bank == '0));

   // R9: idle cycles carry a zero address
   a_r9_nop_addr_zero: assert property (@(posedge clk) disable iff (rst)
      (cmd == CMD_NOP) |-> (sd_addr == '0 && sd_bank == '0));

endmodule

// File: tb/tb_sdram_init_seq.sv
`timescale 1ns/1ps
module tb_sdram_init_seq;

   localparam int AW  = 12;
   localparam int BW  = 2;
   localparam int P   = 37;
   localparam int RP  = 3;
   localparam int RFC = 5;
   localparam int MRD = 2;

   localparam int N_PRE  = P;
   localparam int N_REF1 = P + RP + 1;
   localparam int N_REF2 = N_REF1 + RFC + 1;
   localparam int N_LMR  = N_REF2 + RFC + 1;
   localparam int N_DONE = N_LMR + MRD + 1;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          rst = 1'b1;
   logic [2:0]    blen = '0;
   logic          bt = 1'b0;
   logic [2:0]    cas = '0;
   logic [1:0]    op = '0;
   logic          cs_n, ras_n, cas_n, we_n, done;
   logic [AW-1:0] addr;
   logic [BW-1:0] bank;

   sdram_init_seq #(
      .ADDR_W (AW), .BANK_W (BW), .PWR_CYC (P),
      .T_RP (RP), .T_RFC (RFC), .T_MRD (MRD)
   ) dut (
      .clk (clk), .rst (rst),
      .mode_blen (blen), .mode_seq_type (bt), .mode_cas (cas), .mode_op (op),
      .sd_cs_n (cs_n), .sd_ras_n (ras_n), .sd_cas_n (cas_n), .sd_we_n (we_n),
      .sd_addr (addr), .sd_bank (bank), .init_done (done)
   );

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   function automatic logic [3:0] exp_cmd(input int n);
      if (n == N_PRE)                  return 4'b0010;
      if (n == N_REF1 || n == N_REF2)  return 4'b0001;
      if (n == N_LMR)                  return 4'b0000;
      return 4'b0111;
   endfunction

   function automatic logic [AW-1:0] exp_addr(input int n, input logic [2:0] b,
                                               input logic t, input logic [2:0] c,
                                               input logic [1:0] o);
      logic [AW-1:0] a;
      a = '0;
      if (n == N_PRE) a[10] = 1'b1;
      if (n == N_LMR) a[8:0] = {o, c, t, b};
      return a;
   endfunction

   function automatic string tag_of(input int n);
      if (n < N_PRE)   return "R2";
      if (n == N_PRE)  return "R3";
      if (n < N_REF1)  return "R4";
      if (n < N_LMR)   return "R5";
      if (n == N_LMR)  return "R6";
      if (n < N_DONE)  return "R7";
      return "R8";
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s cyc=%0d actual=%h expected=%h", tag, cyc, act, expv);
      end
   endtask

   task automatic check_cycle(input int n);
      logic [3:0]    ec;
      logic [AW-1:0] ea;
      string         tg;
      ec = exp_cmd(n);
      ea = exp_addr(n, blen, bt, cas, op);
      tg = tag_of(n);
      check({cs_n, ras_n, cas_n, we_n} == ec, tg, 32'({cs_n, ras_n, cas_n, we_n}), 32'(ec));
      check(addr == ea && bank == '0, (ec == 4'b0111) ? "R9" : tg,
            32'({bank, addr}), 32'(ea));
      check(done == (n >= N_DONE), (n >= N_DONE) ? "R7" : tg, 32'(done), 32'(n >= N_DONE));
   endtask

   // Drive reset and check the reset state (R1), release at a falling edge.
   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check({cs_n, ras_n, cas_n, we_n} == 4'b0111 && addr == '0 && bank == '0 && !done,
            "R1", 32'({cs_n, ras_n, cas_n, we_n, done}), 32'({4'b0111, 1'b0}));
      rst = 1'b0;
   endtask

   // Run one sequence; stop_n < 0 runs to completion plus a tail.
   task automatic run_seq(input int stop_n);
      int npre, nref, nlmr, last;
      npre = 0; nref = 0; nlmr = 0;
      last = (stop_n < 0) ? N_DONE + 20 : stop_n;
      do_reset();
      for (int n = 0; n <= last; n++) begin
         if (n > 0) begin
            @(posedge clk);
            @(negedge clk);
         end
         check_cycle(n);
         if ({cs_n, ras_n, cas_n, we_n} == 4'b0010) npre++;
         if ({cs_n, ras_n, cas_n, we_n} == 4'b0001) nref++;
         if ({cs_n, ras_n, cas_n, we_n} == 4'b0000) nlmr++;
      end
      if (stop_n < 0) begin
         // R10: command counts in one full sequence
         check(npre == 1 && nref == 2 && nlmr == 1, "R10",
               32'({npre[7:0], nref[7:0], nlmr[7:0]}), 32'h010201);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         checks++;
         fails++;
         $display("FAIL watchdog cyc=%0d actual=hung expected=finished", cyc);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      // directed: all-zero mode fields
      blen = 3'd0; bt = 1'b0; cas = 3'd0; op = 2'd0;
      run_seq(-1);
      // directed: all-one fields, reserved bits must stay zero (R6)
      blen = 3'd7; bt = 1'b1; cas = 3'd7; op = 2'd3;
      run_seq(-1);
      // random fields
      for (int k = 0; k < 6; k++) begin
         blen = 3'($urandom_range(0, 7));
         bt   = 1'($urandom_range(0, 1));
         cas  = 3'($urandom_range(0, 7));
         op   = 2'($urandom_range(0, 3));
         run_seq(-1);
      end
      // R8: reset at random points mid-sequence, then a full restart
      for (int k = 0; k < 3; k++) begin
         blen = 3'($urandom_range(0, 7));
         cas  = 3'($urandom_range(0, 7));
         run_seq($urandom_range(1, N_DONE + 3));
         run_seq(-1);
      end
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule